// File: doc/BRIEF.md
# Quadrature Encoder Position and Dual-Method Speed Meter

This block takes the three raw lines of an incremental encoder: two quadrature channels and a once-per-turn index. Each line is cleaned with a synchronizer and a stability filter. The two quadrature channels are then decoded at four counts per line cycle into a signed position and a rotation flag. The block also produces two speed measures side by side. The first is the number of decoded edges seen in a fixed time window. The second is the number of system clock cycles between consecutive rising edges on the first channel.

At every window end the block raises a one-cycle strobe. At that strobe the edge count, the latest period and a method-select flag are all stable. The select flag tells software which of the two measures is the more accurate at the present speed. It changes with hysteresis around a crossover edge count. Near standstill the period measure is the better one, and at high speed the edge count is. Converting either count to a speed is left to software or a downstream divider. A mode input decides whether the index pulse clears the position.

Top module: `qenc_mt_speed_meter`

## Requirements
- R1: A level change on the first channel, the second channel or the index line that lasts fewer than FILT_LEN clock cycles after synchronization is ignored and does not move the position.
- R2: Each single-channel transition of the filtered quadrature pair moves pos_o by one. The order (first,second) = 00,10,11,01 counts up, and the reverse order counts down. A transition where both channels change in the same cycle is not counted.
- R3: dir_o is 1 after an up-counting step (first channel leads) and 0 after a down-counting step.
- R4: A filtered rising edge on the index line clears pos_o to 0 when zero_en_i is 1. When zero_en_i is 0 it has no effect.
- R5: valid_o is a one-cycle pulse every WIN_CYC cycles. m_count_o then holds the number of steps counted in the window just closed, in both directions, saturating at all ones. The window counter starts again from zero.
- R6: t_period_o holds the number of clock cycles between the two most recent filtered rising edges of the first channel.
- R7: t_period_o reads all ones after reset until two rising edges have been seen. It also reads all ones whenever no rising edge arrives for 2^TCNT_W-1 cycles, which indicates standstill.
- R8: sel_o (0 = period method, 1 = edge-count method) resets to 0. It changes only together with valid_o. It goes to 1 when m_count_o >= HI_TH, goes to 0 when m_count_o < LO_TH, and otherwise holds its value.
- R9: After reset pos_o = 0, dir_o = 0, m_count_o = 0, sel_o = 0 and valid_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System and reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 1 | Raw first quadrature channel |
| b_i | input | 1 | Raw second quadrature channel |
| z_i | input | 1 | Raw once-per-turn index |
| zero_en_i | input | 1 | Index clears position when 1 |
| pos_o | output | POS_W | Signed position count |
| dir_o | output | 1 | Last step direction, 1 = first channel leads |
| m_count_o | output | MCNT_W | Steps in last window |
| t_period_o | output | TCNT_W | Cycles between first-channel rising edges |
| sel_o | output | 1 | Preferred method, 1 = edge count |
| valid_o | output | 1 | Window-end strobe |

## Verification
The bench steps the encoder at periods that divide the window, so that every full window holds an exact edge count. It then walks the speed through the hysteresis band. It checks a count just below the upper threshold that must leave the flag at 0, a count inside the band that must hold the flag at 1, and a count equal to the lower threshold that must not drop it. A design with the comparisons reversed or made strict in the wrong place would flip the method early or chatter. Standstill is held long enough for the period counter to saturate. A design that wraps the counter instead would report a small period, which reads as a high speed. One-cycle glitches, reverse rotation and the index clear with the mode both on and off are each checked at the position output.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef enum logic {
    SEL_T = 1'b0,
    SEL_M = 1'b1
  } meth_sel_e;

  localparam int unsigned N_LINES = 3;
  localparam int unsigned LINE_A  = 0;
  localparam int unsigned LINE_B  = 1;
  localparam int unsigned LINE_Z  = 2;
endpackage

// File: rtl/qenc_in_filt.sv
module qenc_in_filt #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic clean_o
);
  localparam int unsigned CNT_W = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);

  logic             s1_q, s2_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
    end
  end

  // accept a new level only after FILT_LEN consecutive differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      clean_o <= 1'b0;
    end else if (s2_q != clean_o) begin
      if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
        clean_o <= s2_q;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/qenc_decoder.sv
module qenc_decoder #(
  parameter int unsigned POS_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_i,
  input  logic             b_i,
  input  logic             z_i,
  input  logic             zero_en_i,
  output logic [POS_W-1:0] pos_o,
  output logic             dir_o,
  output logic             step_o,
  output logic             a_rise_o
);
  logic a_q, b_q, z_q;
  logic up;
  logic z_rise;

  always_comb begin
    step_o   = (a_i ^ a_q) ^ (b_i ^ b_q);
    up       = ~(a_q ^ b_i);
    z_rise   = z_i & ~z_q;
    a_rise_o = a_i & ~a_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= 1'b0;
      b_q   <= 1'b0;
      z_q   <= 1'b0;
      pos_o <= '0;
      dir_o <= 1'b0;
    end else begin
      a_q <= a_i;
      b_q <= b_i;
      z_q <= z_i;
      if (step_o) dir_o <= up;
      if (z_rise && zero_en_i) pos_o <= '0;
      else if (step_o)         pos_o <= up ? pos_o + 1'b1 : pos_o - 1'b1;
    end
  end
endmodule

// File: rtl/qenc_m_meter.sv
module qenc_m_meter #(
  parameter int unsigned WIN_CYC = 50000,
  parameter int unsigned MCNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  output logic [MCNT_W-1:0] m_count_o,
  output logic              win_end_o
);
  localparam int unsigned WCNT_W = (WIN_CYC < 2) ? 1 : $clog2(WIN_CYC);
  localparam logic [MCNT_W-1:0] M_MAX = '1;

  logic [WCNT_W-1:0] wcnt_q;
  logic [MCNT_W-1:0] acc_q, acc_nxt;
  logic              last;

  always_comb begin
    last    = (wcnt_q == WCNT_W'(WIN_CYC - 1));
    acc_nxt = (step_i && acc_q != M_MAX) ? acc_q + 1'b1 : acc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q    <= '0;
      acc_q     <= '0;
      m_count_o <= '0;
      win_end_o <= 1'b0;
    end else begin
      win_end_o <= last;
      if (last) begin
        wcnt_q    <= '0;
        m_count_o <= acc_nxt;
        acc_q     <= '0;
      end else begin
        wcnt_q <= wcnt_q + 1'b1;
        acc_q  <= acc_nxt;
      end
    end
  end
endmodule

// File: rtl/qenc_t_meter.sv
module qenc_t_meter #(
  parameter int unsigned TCNT_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_rise_i,
  output logic [TCNT_W-1:0] t_period_o
);
  localparam logic [TCNT_W-1:0] T_MAX = '1;

  logic [TCNT_W-1:0] tcnt_q;
  logic              armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcnt_q     <= '0;
      armed_q    <= 1'b0;
      t_period_o <= T_MAX;
    end else if (a_rise_i) begin
      if (armed_q) t_period_o <= (tcnt_q == T_MAX) ? T_MAX : tcnt_q + 1'b1;
      tcnt_q  <= '0;
      armed_q <= 1'b1;
    end else if (tcnt_q == T_MAX) begin
      t_period_o <= T_MAX; // standstill
    end else begin
      tcnt_q <= tcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/qenc_mt_speed_meter.sv
module qenc_mt_speed_meter #(
  parameter int unsigned POS_W    = 32,
  parameter int unsigned FILT_LEN = 4,
  parameter int unsigned WIN_CYC  = 50000,
  parameter int unsigned MCNT_W   = 16,
  parameter int unsigned TCNT_W   = 20,
  parameter int unsigned HI_TH    = 940,
  parameter int unsigned LO_TH    = 850
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_i,
  input  logic              b_i,
  input  logic              z_i,
  input  logic              zero_en_i,
  output logic [POS_W-1:0]  pos_o,
  output logic              dir_o,
  output logic [MCNT_W-1:0] m_count_o,
  output logic [TCNT_W-1:0] t_period_o,
  output logic              sel_o,
  output logic              valid_o
);
  import qenc_pkg::*;

  logic [N_LINES-1:0] raw, clean;
  logic               step, a_rise, win_end;
  meth_sel_e          sel_q;

  assign raw = {z_i, b_i, a_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_filt
    qenc_in_filt #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw[g]),
      .clean_o(clean[g])
    );
  end

  qenc_decoder #(.POS_W(POS_W)) u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .a_i      (clean[LINE_A]),
    .b_i      (clean[LINE_B]),
    .z_i      (clean[LINE_Z]),
    .zero_en_i(zero_en_i),
    .pos_o    (pos_o),
    .dir_o    (dir_o),
    .step_o   (step),
    .a_rise_o (a_rise)
  );

  qenc_m_meter #(.WIN_CYC(WIN_CYC), .MCNT_W(MCNT_W)) u_m (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step),
    .m_count_o(m_count_o),
    .win_end_o(win_end)
  );

  qenc_t_meter #(.TCNT_W(TCNT_W)) u_t (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_rise_i  (a_rise),
    .t_period_o(t_period_o)
  );

  // hysteretic method select, decided on the freshly latched window count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= SEL_T;
      valid_o <= 1'b0;
    end else begin
      valid_o <= win_end;
      if (win_end) begin
        if (sel_q == SEL_T && m_count_o >= MCNT_W'(HI_TH))     sel_q <= SEL_M;
        else if (sel_q == SEL_M && m_count_o < MCNT_W'(LO_TH)) sel_q <= SEL_T;
      end
    end
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/qenc_mt_checker.sv
module qenc_mt_checker #(
  parameter int unsigned POS_W  = 32,
  parameter int unsigned MCNT_W = 16,
  parameter int unsigned TCNT_W = 20,
  parameter int unsigned HI_TH  = 940,
  parameter int unsigned LO_TH  = 850
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [POS_W-1:0]  pos_o,
  input logic [MCNT_W-1:0] m_count_o,
  input logic [TCNT_W-1:0] t_period_o,
  input logic              sel_o,
  input logic              valid_o
);
  // R2 / R4: position moves by one or is cleared
  p_pos_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_o != $past(pos_o)) |->
      (pos_o == $past(pos_o) + POS_W'(1) || pos_o == $past(pos_o) - POS_W'(1) || pos_o == '0));

  p_valid_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_mcount_then_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_count_o != $past(m_count_o)) |-> ##1 valid_o);

  p_sel_with_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o != $past(sel_o)) |-> valid_o);

  p_sel_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_o) |-> (m_count_o >= MCNT_W'(HI_TH)));

  p_sel_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sel_o) |-> (m_count_o < MCNT_W'(LO_TH)));

  p_tper_nonzero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_period_o != '0);
endmodule

bind qenc_mt_speed_meter qenc_mt_checker #(
  .POS_W(POS_W), .MCNT_W(MCNT_W), .TCNT_W(TCNT_W), .HI_TH(HI_TH), .LO_TH(LO_TH)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pos_o     (pos_o),
  .m_count_o (m_count_o),
  .t_period_o(t_period_o),
  .sel_o     (sel_o),
  .valid_o   (valid_o)
);

// File: tb/qenc_mt_speed_meter_tb.sv
module qenc_mt_speed_meter_tb;
  localparam int unsigned POS_W = 16, FILT_LEN = 3, WIN_CYC = 480;
  localparam int unsigned MCNT_W = 12, TCNT_W = 12, HI_TH = 40, LO_TH = 30;
  localparam logic [TCNT_W-1:0] T_SAT = '1;

  typedef struct {
    int m;
    int t;
    bit sel;
  } item_t;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic a_i = 1'b0, b_i = 1'b0, z_i = 1'b0, zero_en_i = 1'b0;
  logic [POS_W-1:0]  pos_o;
  logic              dir_o, sel_o, valid_o;
  logic [MCNT_W-1:0] m_count_o;
  logic [TCNT_W-1:0] t_period_o;

  int checks = 0, errors = 0, win_seen = 0;
  int cur_p = 0;
  bit cur_dir = 1'b1, done = 1'b0, prev_valid = 1'b0;
  int phase = 0;
  logic [POS_W-1:0] model_pos = '0;
  item_t q[$];

  always #2 clk_i = ~clk_i;

  qenc_mt_speed_meter #(
    .POS_W(POS_W), .FILT_LEN(FILT_LEN), .WIN_CYC(WIN_CYC), .MCNT_W(MCNT_W),
    .TCNT_W(TCNT_W), .HI_TH(HI_TH), .LO_TH(LO_TH)
  ) u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // stimulus: (a,b) phases 00,10,11,01; up order when cur_dir=1
  initial begin
    forever begin
      if (cur_p == 0) @(posedge clk_i);
      else begin
        repeat (cur_p) @(posedge clk_i);
        #1;
        if (cur_dir) begin phase = (phase + 1) % 4; model_pos = model_pos + 1'b1; end
        else         begin phase = (phase + 3) % 4; model_pos = model_pos - 1'b1; end
        a_i = (phase == 1 || phase == 2);
        b_i = (phase == 2 || phase == 3);
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (prev_valid) chk(!valid_o, "R5 valid width", int'(valid_o), 0);
      prev_valid = valid_o;
      if (valid_o) begin
        if (q.size() > 0) begin
          item_t it;
          it = q.pop_front();
          chk(int'(m_count_o) == it.m, "R5 m_count", int'(m_count_o), it.m);
          chk(int'(t_period_o) == it.t, (it.t == int'(T_SAT)) ? "R7 t_sat" : "R6 t_period",
              int'(t_period_o), it.t);
          chk(sel_o == it.sel, "R8 sel", int'(sel_o), int'(it.sel));
        end
        win_seen++;
      end
    end
  end

  task automatic run_speed(input int p, input bit d, input int skip, input int n, input bit exp_sel);
    int tgt;
    item_t it;
    cur_dir = d;
    cur_p   = p;
    tgt = win_seen + skip;
    wait (win_seen >= tgt);
    it.m   = (p == 0) ? 0 : int'(WIN_CYC) / p;
    it.t   = (p == 0) ? int'(T_SAT) : 4 * p;
    it.sel = exp_sel;
    for (int i = 0; i < n; i++) q.push_back(it);
    wait (win_seen >= tgt + n);
  endtask

  task automatic stop_settle();
    cur_p = 0;
    repeat (100) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(pos_o == '0, "R9 pos", int'(pos_o), 0);
    chk(dir_o == 1'b0, "R9 dir", int'(dir_o), 0);
    chk(m_count_o == '0, "R9 m_count", int'(m_count_o), 0);
    chk(sel_o == 1'b0, "R9 sel", int'(sel_o), 0);
    chk(valid_o == 1'b0, "R9 valid", int'(valid_o), 0);
    chk(t_period_o == T_SAT, "R7 t at reset", int'(t_period_o), int'(T_SAT));

    // R1: two-cycle glitches on a and b
    @(posedge clk_i); #1 a_i = 1'b1;
    repeat (2) @(posedge clk_i); #1 a_i = 1'b0;
    @(posedge clk_i); #1 b_i = 1'b1;
    repeat (2) @(posedge clk_i); #1 b_i = 1'b0;
    repeat (20) @(negedge clk_i);
    chk(pos_o == '0, "R1 glitch ignored", int'(pos_o), 0);

    // speed sweep through hysteresis band (window 480)
    run_speed(20, 1'b1, 2, 2, 1'b0); // 24
    run_speed(15, 1'b1, 2, 2, 1'b0); // 32 below HI: stays T
    run_speed(12, 1'b1, 2, 2, 1'b1); // 40 = HI: M
    run_speed(15, 1'b1, 2, 2, 1'b1); // 32 in band: holds M
    run_speed(16, 1'b1, 2, 2, 1'b1); // 30 = LO: holds M
    run_speed(20, 1'b1, 2, 2, 1'b0); // 24 below LO: T
    stop_settle();
    chk(pos_o == model_pos, "R2 pos after up run", int'(pos_o), int'(model_pos));
    chk(dir_o == 1'b1, "R3 dir up", int'(dir_o), 1);

    run_speed(12, 1'b0, 2, 2, 1'b1); // reverse, 40
    stop_settle();
    chk(pos_o == model_pos, "R2 pos after down run", int'(pos_o), int'(model_pos));
    chk(dir_o == 1'b0, "R3 dir down", int'(dir_o), 0);

    run_speed(0, 1'b0, 11, 2, 1'b0); // standstill: saturated period, select falls

    // R1: short index glitch with clear enabled
    zero_en_i = 1'b1;
    @(posedge clk_i); #1 z_i = 1'b1;
    repeat (2) @(posedge clk_i); #1 z_i = 1'b0;
    repeat (20) @(negedge clk_i);
    chk(pos_o == model_pos, "R1 index glitch ignored", int'(pos_o), int'(model_pos));

    // R4: index clears when enabled
    @(posedge clk_i); #1 z_i = 1'b1;
    repeat (10) @(posedge clk_i); #1 z_i = 1'b0;
    repeat (20) @(negedge clk_i);
    chk(pos_o == '0, "R4 index clear", int'(pos_o), 0);
    model_pos = '0;

    // R4: index ignored when disabled
    zero_en_i = 1'b0;
    cur_dir = 1'b1;
    cur_p = 10;
    repeat (75) @(posedge clk_i);
    stop_settle();
    @(posedge clk_i); #1 z_i = 1'b1;
    repeat (10) @(posedge clk_i); #1 z_i = 1'b0;
    repeat (20) @(negedge clk_i);
    chk(pos_o == model_pos && model_pos != '0, "R4 index ignored", int'(pos_o), int'(model_pos));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", win_seen, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule